// File: doc/BRIEF.md
# Byte-Register Multiply/Divide Unit

This unit gives a host an unsigned arithmetic engine behind a small set of byte-wide registers. The host loads an 8-bit multiplicand and then writes an 8-bit multiplier, which starts an 8x8 multiply. For a division it loads a 16-bit dividend one byte at a time and then writes an 8-bit divisor, which starts a 16-by-8 division. Each operation works one bit per clock on a private copy of its operands, so the host may rewrite the operand registers while an operation is still running.

Results come back as 16-bit values read one byte at a time. The quotient has a register of its own. The product and the remainder share a single result register, which holds the outcome of whichever operation finished last. A zero divisor is legal: the quotient becomes all ones and the remainder is the unchanged dividend. A busy flag covers the run of an operation, and a one-cycle done pulse marks the clock in which the results were written.

Top module: `muldiv_unit`

## Requirements
- R1: After a synchronous active-low reset, every readable register (addresses 0 to 8) reads 0x00, and busy and done are low.
- R2: Address map: 0 multiplicand, 1 multiplier, 2 dividend low byte, 3 dividend high byte, 4 divisor, 5 quotient low, 6 quotient high, 7 shared result low, 8 shared result high. While rd_en is high, rdata shows the addressed byte in the same cycle, and any address from 9 to 15 reads 0x00. While rd_en is low, rdata is 0x00.
- R3: A write to address 0 only stores the multiplicand. The byte reads back at address 0, and busy stays low.
- R4: A write to address 1 stores the multiplier and starts a multiply. Eight clocks after the write edge, the shared result holds the 16-bit unsigned product of the multiplicand and the new multiplier.
- R5: A write to address 2 or 3 replaces only that byte of the dividend. The other byte keeps its value.
- R6: A write to address 4 stores the divisor and starts a divide. Sixteen clocks after the write edge, the quotient register holds dividend / divisor and the shared result holds dividend % divisor, replacing any earlier product.
- R7: With a zero divisor, the quotient becomes 0xFFFF and the shared result becomes the dividend, with the same 16-clock timing.
- R8: busy is high in each cycle that follows a starting write edge, up to and including the cycle of the edge that writes the results. done is high for exactly one cycle, right after that edge. The quotient and the shared result do not change while an operation is running.
- R9: A starting write while busy restarts the operation with the new operands and a full count. The interrupted operation writes no result, except when it finishes on the same edge as the new start. In that case its results are written and the new operation still runs.
- R10: The operand registers keep their values after an operation. Rewriting only the multiplier or only the divisor reuses the stored other operand.
- R11: Writes to addresses 5 to 15 change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, acts on the rising clock edge |
| rd_en | input | 1 | Read strobe, gates rdata |
| rdata | output | 8 | Read data, combinational from addr |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse after the results are written |

## Verification
The hardest case to reach from the ports is a new starting write that lands on the very edge where a running operation writes its results. This requires a start write placed exactly eight clocks after a multiply start. The bench counts idle cycles so that the second write of the multiplier falls on that edge. The bench also aborts divides in mid-run and issues back-to-back starts of the other kind, to show that stale intermediate state never reaches the result registers. A behavioural model built from integer arithmetic and a countdown predicts busy, done and rdata on every clock.

// File: rtl/muldiv_pkg.sv
// Shared widths, register addresses and operation codes for the
// multiply/divide unit. Assumes an 8-bit host data bus.
package muldiv_pkg;
    parameter int unsigned BYTE_W    = 8;
    parameter int unsigned ADDR_W    = 4;
    localparam int unsigned WIDE_W   = 2 * BYTE_W;
    localparam int unsigned MUL_STEPS = BYTE_W;
    localparam int unsigned DIV_STEPS = WIDE_W;
    localparam int unsigned CNT_W    = $clog2(DIV_STEPS + 1);

    localparam logic [ADDR_W-1:0] ADR_MCAND   = 4'd0;
    localparam logic [ADDR_W-1:0] ADR_MPLIER  = 4'd1;
    localparam logic [ADDR_W-1:0] ADR_DVD_LO  = 4'd2;
    localparam logic [ADDR_W-1:0] ADR_DVD_HI  = 4'd3;
    localparam logic [ADDR_W-1:0] ADR_DIVISOR = 4'd4;
    localparam logic [ADDR_W-1:0] ADR_QUO_LO  = 4'd5;
    localparam logic [ADDR_W-1:0] ADR_QUO_HI  = 4'd6;
    localparam logic [ADDR_W-1:0] ADR_RES_LO  = 4'd7;
    localparam logic [ADDR_W-1:0] ADR_RES_HI  = 4'd8;

    typedef enum logic {OP_MUL = 1'b0, OP_DIV = 1'b1} op_e;
endpackage

// File: rtl/muldiv_operands.sv
// Operand register file: multiplicand, multiplier, 16-bit dividend
// (written bytewise) and divisor. It also decodes the two starting writes.
// Assumes at most one write per cycle.
module muldiv_operands
    import muldiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              wr_en,
    output logic [BYTE_W-1:0] mcand_q,
    output logic [BYTE_W-1:0] mplier_q,
    output logic [WIDE_W-1:0] dividend_q,
    output logic [BYTE_W-1:0] divisor_q,
    output logic              start_mul,
    output logic              start_div
);
    // Start decode: the multiplier and divisor writes launch operations.
    always_comb begin
        start_mul = wr_en && (addr == ADR_MPLIER);
        start_div = wr_en && (addr == ADR_DIVISOR);
    end

    // Operand storage: each address updates only its own byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand_q    <= '0;
            mplier_q   <= '0;
            dividend_q <= '0;
            divisor_q  <= '0;
        end else if (wr_en) begin
            case (addr)
                ADR_MCAND:   mcand_q <= wdata;
                ADR_MPLIER:  mplier_q <= wdata;
                ADR_DVD_LO:  dividend_q[BYTE_W-1:0] <= wdata;
                ADR_DVD_HI:  dividend_q[WIDE_W-1:BYTE_W] <= wdata;
                ADR_DIVISOR: divisor_q <= wdata;
                default: ;
            endcase
        end
    end

    // R5: a low-byte write leaves the high byte alone, and the reverse.
    a_r5_dvd_lo_keeps_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADR_DVD_LO) |=> dividend_q[WIDE_W-1:BYTE_W] == $past(dividend_q[WIDE_W-1:BYTE_W]));
    a_r5_dvd_hi_keeps_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADR_DVD_HI) |=> dividend_q[BYTE_W-1:0] == $past(dividend_q[BYTE_W-1:0]));
endmodule

// File: rtl/muldiv_engine.sv
// Sequential arithmetic core. It runs a shift-add multiply (one multiplier
// bit per clock) and a restoring shift-subtract divide (one quotient bit per
// clock) on private copies of the operands. A start always reloads it.
// On the last step it presents the final values together with write enables.
module muldiv_engine
    import muldiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_mul,
    input  logic              start_div,
    input  logic [BYTE_W-1:0] mcand,
    input  logic [BYTE_W-1:0] new_b,
    input  logic [WIDE_W-1:0] dividend,
    output logic              busy,
    output logic              done,
    output logic              quo_we,
    output logic              res_we,
    output logic [WIDE_W-1:0] quo_val,
    output logic [WIDE_W-1:0] res_val
);
    op_e               op_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [WIDE_W-1:0] acc_q;      // product accumulator, or dividend/quotient shifter
    logic [WIDE_W-1:0] mc_q;       // shifted multiplicand
    logic [BYTE_W-1:0] mp_q;       // shifted multiplier
    logic [BYTE_W-1:0] rem_q;      // partial remainder
    logic [BYTE_W-1:0] dv_q;       // divisor copy
    logic [WIDE_W-1:0] dvd_keep_q; // dividend copy for the zero-divisor rule
    logic              busy_q;
    logic              done_q;

    logic [BYTE_W:0]   trial;
    logic              fits;
    logic [BYTE_W-1:0] diff;
    logic [BYTE_W-1:0] rem_next;
    logic [WIDE_W-1:0] acc_next;
    logic              last_step;

    // One step of the datapath, selected by the running operation.
    always_comb begin
        trial    = {rem_q, acc_q[WIDE_W-1]};
        fits     = trial >= {1'b0, dv_q};
        diff     = trial[BYTE_W-1:0] - dv_q;
        rem_next = fits ? diff : trial[BYTE_W-1:0];
        if (op_q == OP_MUL)
            acc_next = acc_q + (mp_q[0] ? mc_q : '0);
        else
            acc_next = {acc_q[WIDE_W-2:0], fits};
    end

    // Final values and write enables on the last step.
    always_comb begin
        last_step = busy_q && (cnt_q == CNT_W'(1));
        quo_we    = last_step && (op_q == OP_DIV);
        res_we    = last_step;
        quo_val   = (dv_q == '0) ? '1 : acc_next;
        if (op_q == OP_MUL)
            res_val = acc_next;
        else if (dv_q == '0)
            res_val = dvd_keep_q;
        else
            res_val = {{(WIDE_W-BYTE_W){1'b0}}, rem_next};
    end

    // Sequencer: a start reloads everything, otherwise step while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q       <= OP_MUL;
            cnt_q      <= '0;
            acc_q      <= '0;
            mc_q       <= '0;
            mp_q       <= '0;
            rem_q      <= '0;
            dv_q       <= '0;
            dvd_keep_q <= '0;
            busy_q     <= 1'b0;
            done_q     <= 1'b0;
        end else begin
            done_q <= last_step;
            if (start_mul) begin
                op_q   <= OP_MUL;
                cnt_q  <= CNT_W'(MUL_STEPS);
                acc_q  <= '0;
                mc_q   <= {{(WIDE_W-BYTE_W){1'b0}}, mcand};
                mp_q   <= new_b;
                busy_q <= 1'b1;
            end else if (start_div) begin
                op_q       <= OP_DIV;
                cnt_q      <= CNT_W'(DIV_STEPS);
                acc_q      <= dividend;
                rem_q      <= '0;
                dv_q       <= new_b;
                dvd_keep_q <= dividend;
                busy_q     <= 1'b1;
            end else if (busy_q) begin
                acc_q  <= acc_next;
                rem_q  <= rem_next;
                mc_q   <= {mc_q[WIDE_W-2:0], 1'b0};
                mp_q   <= {1'b0, mp_q[BYTE_W-1:1]};
                cnt_q  <= cnt_q - CNT_W'(1);
                if (last_step) busy_q <= 1'b0;
            end
        end
    end

    assign busy = busy_q;
    assign done = done_q;

    // R8: a start is always followed by a busy cycle.
    a_r8_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start_mul || start_div) |=> busy);
    // R8: busy only drops together with the done pulse.
    a_r8_done_on_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    // R8: the step counter stays inside its range while running.
    a_r8_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt_q != '0 && cnt_q <= CNT_W'(DIV_STEPS)));
endmodule

// File: rtl/muldiv_results.sv
// Result storage and read-back. It holds the quotient and the shared
// product/remainder register, and drives the byte read mux for all registers.
// Assumes the engine raises its write enables only on a final step.
module muldiv_results
    import muldiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              quo_we,
    input  logic              res_we,
    input  logic [WIDE_W-1:0] quo_val,
    input  logic [WIDE_W-1:0] res_val,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic [BYTE_W-1:0] mcand_q,
    input  logic [BYTE_W-1:0] mplier_q,
    input  logic [WIDE_W-1:0] dividend_q,
    input  logic [BYTE_W-1:0] divisor_q,
    output logic [BYTE_W-1:0] rdata
);
    logic [WIDE_W-1:0] quo_q;
    logic [WIDE_W-1:0] res_q;

    // Result capture on the engine's final step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quo_q <= '0;
            res_q <= '0;
        end else begin
            if (quo_we) quo_q <= quo_val;
            if (res_we) res_q <= res_val;
        end
    end

    // Byte read mux, gated by the read strobe.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (addr)
                ADR_MCAND:   rdata = mcand_q;
                ADR_MPLIER:  rdata = mplier_q;
                ADR_DVD_LO:  rdata = dividend_q[BYTE_W-1:0];
                ADR_DVD_HI:  rdata = dividend_q[WIDE_W-1:BYTE_W];
                ADR_DIVISOR: rdata = divisor_q;
                ADR_QUO_LO:  rdata = quo_q[BYTE_W-1:0];
                ADR_QUO_HI:  rdata = quo_q[WIDE_W-1:BYTE_W];
                ADR_RES_LO:  rdata = res_q[BYTE_W-1:0];
                ADR_RES_HI:  rdata = res_q[WIDE_W-1:BYTE_W];
                default:     rdata = '0;
            endcase
        end
    end

    // R8: the results move only on a final engine step.
    a_r8_res_stable_midrun: assert property (@(posedge clk) disable iff (!rst_n)
        !res_we |=> $stable(res_q));
    a_r8_quo_stable_midrun: assert property (@(posedge clk) disable iff (!rst_n)
        !quo_we |=> $stable(quo_q));
    // R2: with no read strobe the bus stays quiet.
    a_r2_idle_bus_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> rdata == '0);
endmodule

// File: rtl/muldiv_unit.sv
// Top of the multiply/divide unit. It wires the operand registers, the
// sequential engine and the result/read-back block together.
// Assumes a single host that issues at most one write per cycle.
module muldiv_unit
    import muldiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [BYTE_W-1:0] rdata,
    output logic              busy,
    output logic              done
);
    logic [BYTE_W-1:0] mcand_q;
    logic [BYTE_W-1:0] mplier_q;
    logic [WIDE_W-1:0] dividend_q;
    logic [BYTE_W-1:0] divisor_q;
    logic              start_mul;
    logic              start_div;
    logic              quo_we;
    logic              res_we;
    logic [WIDE_W-1:0] quo_val;
    logic [WIDE_W-1:0] res_val;

    muldiv_operands u_operands (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (addr),
        .wdata      (wdata),
        .wr_en      (wr_en),
        .mcand_q    (mcand_q),
        .mplier_q   (mplier_q),
        .dividend_q (dividend_q),
        .divisor_q  (divisor_q),
        .start_mul  (start_mul),
        .start_div  (start_div)
    );

    muldiv_engine u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_mul (start_mul),
        .start_div (start_div),
        .mcand     (mcand_q),
        .new_b     (wdata),
        .dividend  (dividend_q),
        .busy      (busy),
        .done      (done),
        .quo_we    (quo_we),
        .res_we    (res_we),
        .quo_val   (quo_val),
        .res_val   (res_val)
    );

    muldiv_results u_results (
        .clk        (clk),
        .rst_n      (rst_n),
        .quo_we     (quo_we),
        .res_we     (res_we),
        .quo_val    (quo_val),
        .res_val    (res_val),
        .addr       (addr),
        .rd_en      (rd_en),
        .mcand_q    (mcand_q),
        .mplier_q   (mplier_q),
        .dividend_q (dividend_q),
        .divisor_q  (divisor_q),
        .rdata      (rdata)
    );

    // R1: the cycle after a reset edge shows an idle unit.
    a_r1_idle_after_reset: assert property (@(posedge clk)
        $past(!rst_n) |-> (!busy && !done));
endmodule

// File: tb/test_muldiv_unit.sv
`timescale 1ns/1ps
// Bench: a behavioural model (integer arithmetic plus a countdown) is
// compared with busy, done and rdata at every falling edge.
module test_muldiv_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rdata;
    logic       busy;
    logic       done;

    int checks = 0;
    int errors = 0;
    string req = "R1";
    bit compare_on = 1'b0;

    // model state
    int m_a = 0, m_b = 0, m_dvd = 0, m_dv = 0, m_q = 0, m_r = 0;
    int m_left = 0, p_q = 0, p_r = 0;
    bit m_busy = 0, m_done = 0, p_div = 0;

    muldiv_unit i_muldiv_unit (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .busy(busy), .done(done)
    );

    always #10 clk = ~clk;

    // Reference model, advanced at each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_a = 0; m_b = 0; m_dvd = 0; m_dv = 0; m_q = 0; m_r = 0;
            m_left = 0; m_busy = 0; m_done = 0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                m_left--;
                if (m_left == 0) begin
                    m_r = p_r;
                    if (p_div) m_q = p_q;
                    m_busy = 0;
                    m_done = 1;
                end
            end
            if (wr_en) begin
                case (addr)
                    4'd0: m_a = wdata;
                    4'd1: begin
                        m_b = wdata; p_div = 0; p_r = m_a * m_b;
                        m_left = 8; m_busy = 1;
                    end
                    4'd2: m_dvd = (m_dvd & 16'hFF00) | wdata;
                    4'd3: m_dvd = (m_dvd & 16'h00FF) | (int'(wdata) << 8);
                    4'd4: begin
                        m_dv = wdata; p_div = 1;
                        p_q = (m_dv != 0) ? m_dvd / m_dv : 16'hFFFF;
                        p_r = (m_dv != 0) ? m_dvd % m_dv : m_dvd;
                        m_left = 16; m_busy = 1;
                    end
                    default: ;
                endcase
            end
        end
    end

    function automatic int model_rd(input logic [3:0] a, input logic r);
        if (!r) return 0;
        case (a)
            4'd0: return m_a;
            4'd1: return m_b;
            4'd2: return m_dvd & 255;
            4'd3: return (m_dvd >> 8) & 255;
            4'd4: return m_dv;
            4'd5: return m_q & 255;
            4'd6: return (m_q >> 8) & 255;
            4'd7: return m_r & 255;
            4'd8: return (m_r >> 8) & 255;
            default: return 0;
        endcase
    endfunction

    task automatic check(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // One bench cycle: compare at the falling edge, then drive new inputs.
    task automatic cyc(input logic [3:0] a, input logic [7:0] d, input logic w, input logic r);
        @(negedge clk);
        if (compare_on) begin
            check("busy", int'(busy), int'(m_busy));
            check("done", int'(done), int'(m_done));
            check("rdata", int'(rdata), model_rd(addr, rd_en));
        end
        addr = a; wdata = d; wr_en = w; rd_en = r;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        cyc(a, d, 1'b1, 1'b0);
    endtask

    task automatic rd(input logic [3:0] a);
        cyc(a, 8'h00, 1'b0, 1'b1);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(4'd0, 8'h00, 1'b0, 1'b0);
    endtask

    task automatic read_all();
        for (int i = 0; i < 16; i++) rd(4'(i));
    endtask

    // Watchdog: a hung run is counted as a failure.
    initial begin
        #4_000_000;
        checks++; errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        compare_on = 1'b1;
        req = "R1"; read_all();                       // reset state, all zero
        rst_n = 1'b1;
        req = "R2"; cyc(4'd0, 8'h00, 1'b0, 1'b0); read_all();
        req = "R3"; wr(4'd0, 8'hFF); rd(4'd0); idle(2);
        req = "R4"; wr(4'd1, 8'hFF);                  // 255*255 = 0xFE01
        req = "R8"; rd(4'd7); rd(4'd8); idle(6); rd(4'd7); rd(4'd8);
        req = "R5"; wr(4'd2, 8'hCD); wr(4'd3, 8'hAB); rd(4'd2); rd(4'd3);
        wr(4'd2, 8'h11); rd(4'd3); wr(4'd2, 8'hCD);
        req = "R6"; wr(4'd4, 8'h07); idle(17); read_all();
        wr(4'd4, 8'hFF); idle(17); read_all();
        req = "R7"; wr(4'd4, 8'h00); idle(17); read_all();
        req = "R9"; wr(4'd4, 8'h03); idle(6); wr(4'd4, 8'h10); idle(9); wr(4'd1, 8'h02);
        idle(10); read_all();
        // start on the exact finishing edge of a multiply
        wr(4'd0, 8'h21); wr(4'd1, 8'h05); idle(7); wr(4'd1, 8'h09); idle(9); read_all();
        req = "R10"; wr(4'd1, 8'h80); idle(9); rd(4'd7); rd(4'd8);
        wr(4'd4, 8'h01); idle(17); read_all();
        req = "R11"; for (int a = 5; a < 16; a++) wr(4'(a), 8'h5A);
        idle(2); read_all();
        req = "R2"; cyc(4'd5, 8'h00, 1'b0, 1'b0); cyc(4'd9, 8'h00, 1'b0, 1'b1);
        req = "R1"; rst_n = 1'b0; wr(4'd1, 8'h33); idle(2); rst_n = 1'b1; read_all();
        idle(2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule